// File: doc/BRIEF.md
# Parallel Flash Byte/Word Program Sequencer

This block sits on the host side of an asynchronous parallel NOR-style flash bus and drives the command sequence that programs one byte or word. The host pulses `start` with an address and a data word. The block writes the program-setup command and then the data to the same address. It reads the device status until the ready bit rises, then decodes the three sticky error bits in a fixed priority and returns a 3-bit result code through a start/busy/done handshake.

When the operation ends in any error, including a poll timeout, the block writes the clear-status command before it reports `done`. That way the host can retry at once. The same handshake with `array_req` set writes the read-array command, which puts the device back in normal read mode after the last program. Bus strobe widths come from parameters counted in clock cycles.

Top module: `flash_prog_seq`

## Requirements
- R1: A program request produces exactly two bus writes, both to the requested address: first data 0x40, then the requested data word.
- R2: Every bus write holds `flash_we_n` low for exactly WE_CYC clock cycles, with `flash_ce_n` low, `flash_dq_oe` high, and address and write data unchanged for the whole pulse.
- R3: After the data write, status reads follow. Each read holds `flash_oe_n` low for exactly OE_CYC cycles with `flash_we_n` high and `flash_dq_oe` low. Reads repeat while status bit 7 is 0, so a device that reports busy on N reads gets N+1 reads.
- R4: Once bit 7 reads 1, the result is decoded in this priority: bit 3 set gives code 1 (voltage error), else bit 1 set gives code 2 (protect error), else bit 4 set gives code 3 (program error), else code 0 (success).
- R5: If the result is nonzero, one extra bus write of 0x50 to the same address takes place before `done`. A success code produces no such write.
- R6: If MAX_POLLS consecutive reads all show bit 7 at 0, the block stops polling, writes 0x50 and reports code 4 (timeout).
- R7: A request with `array_req` high produces a single bus write of 0xFF to the given address and reports code 0, with no status read.
- R8: `busy` goes high on the cycle after an accepted `start` and stays high until `done`. `done` is a single-cycle pulse with `result` valid. A `start` raised while `busy` is high causes no bus activity.
- R9: After reset, `busy` and `done` are low and `flash_ce_n`, `flash_we_n` and `flash_oe_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted when not busy |
| array_req | input | 1 | With start: write the read-array command instead of programming |
| addr_in | input | AW | Target address |
| data_in | input | DW | Word to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0 ok, 1 voltage, 2 protect, 3 program error, 4 timeout |
| flash_addr | output | AW | Flash address bus |
| flash_dq_out | output | DW | Flash write data |
| flash_dq_oe | output | 1 | Drive enable for the data bus |
| flash_stat_in | input | 8 | Low byte of the flash data bus during reads |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |

## Verification
A behavioural flash model answers the status reads. The bench varies how many reads come back busy: none, a few, or more than the poll limit. This separates a single-poll path from the loop and from the timeout exit. Error bits are applied singly and in overlapping combinations, so a wrong decode priority gives the wrong code. A success case confirms that no clear write is issued. A read-array request and a `start` pulse during a busy operation show that the command selection is correct and that the block ignores a second request.

// File: rtl/flash_prog_seq.sv
module flash_prog_seq #(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int WE_CYC = 3,
  parameter int OE_CYC = 2,
  parameter int MAX_POLLS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          array_req,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic          busy,
  output logic          done,
  output logic [2:0]    result,
  output logic [AW-1:0] flash_addr,
  output logic [DW-1:0] flash_dq_out,
  output logic          flash_dq_oe,
  input  logic [7:0]    flash_stat_in,
  output logic          flash_ce_n,
  output logic          flash_we_n,
  output logic          flash_oe_n
);
  localparam int MAXC = (WE_CYC > OE_CYC) ? WE_CYC : OE_CYC;
  localparam int CW = $clog2(MAXC + 1) + 1;
  localparam int PW = $clog2(MAX_POLLS + 1) + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_WSET, S_WDAT, S_RSTAT, S_WCLR, S_WARR, S_FIN
  } state_t;

  state_t          state;
  logic [CW-1:0]   cnt;
  logic [PW-1:0]   polls;
  logic [AW-1:0]   addr_r;
  logic [DW-1:0]   data_r;
  logic [7:0]      stat_r;
  logic [2:0]      res_r;
  logic [2:0]      decode;
  logic            wr_st, rd_st;

  assign wr_st = (state == S_WSET) || (state == S_WDAT) ||
                 (state == S_WCLR) || (state == S_WARR);
  assign rd_st = (state == S_RSTAT);

  assign decode = stat_r[3] ? 3'd1 :
                  stat_r[1] ? 3'd2 :
                  stat_r[4] ? 3'd3 : 3'd0;

  assign busy        = (state != S_IDLE);
  assign done        = (state == S_FIN);
  assign result      = res_r;
  assign flash_addr  = addr_r;
  assign flash_dq_oe = wr_st;
  assign flash_ce_n  = !(wr_st || rd_st);
  assign flash_we_n  = !(wr_st && (cnt < CW'(WE_CYC)));
  assign flash_oe_n  = !(rd_st && (cnt < CW'(OE_CYC)));

  always_comb begin
    case (state)
      S_WSET:  flash_dq_out = DW'(8'h40);
      S_WDAT:  flash_dq_out = data_r;
      S_WCLR:  flash_dq_out = DW'(8'h50);
      S_WARR:  flash_dq_out = DW'(8'hFF);
      default: flash_dq_out = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      polls  <= '0;
      addr_r <= '0;
      data_r <= '0;
      stat_r <= '0;
      res_r  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          addr_r <= addr_in;
          data_r <= data_in;
          cnt    <= '0;
          polls  <= '0;
          res_r  <= '0;
          state  <= array_req ? S_WARR : S_WSET;
        end
        S_WSET, S_WDAT, S_WCLR, S_WARR: begin
          if (cnt == CW'(WE_CYC)) begin
            cnt <= '0;
            case (state)
              S_WSET:  state <= S_WDAT;
              S_WDAT:  state <= S_RSTAT;
              default: state <= S_FIN;
            endcase
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RSTAT: begin
          if (cnt == CW'(OE_CYC - 1)) stat_r <= flash_stat_in;
          if (cnt == CW'(OE_CYC)) begin
            cnt   <= '0;
            polls <= polls + 1'b1;
            if (stat_r[7]) begin
              res_r <= decode;
              state <= (decode != 3'd0) ? S_WCLR : S_FIN;
            end else if (polls + 1'b1 == PW'(MAX_POLLS)) begin
              res_r <= 3'd4;
              state <= S_WCLR;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk #(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [2:0]    result,
  input logic [AW-1:0] flash_addr,
  input logic [DW-1:0] flash_dq_out,
  input logic          flash_dq_oe,
  input logic          flash_ce_n,
  input logic          flash_we_n,
  input logic          flash_oe_n
);
  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!flash_we_n && !flash_oe_n));
  assert_read_no_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_oe_n |-> !flash_dq_oe);
  assert_strobe_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_we_n || !flash_oe_n) |-> !flash_ce_n);
  assert_write_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_we_n && $past(!flash_we_n)) |-> ($stable(flash_addr) && $stable(flash_dq_out)));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  assert_result_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result <= 3'd4));
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (flash_we_n && flash_oe_n && flash_ce_n));
endmodule

bind flash_prog_seq flash_prog_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .result(result),
  .flash_addr(flash_addr), .flash_dq_out(flash_dq_out), .flash_dq_oe(flash_dq_oe),
  .flash_ce_n(flash_ce_n), .flash_we_n(flash_we_n), .flash_oe_n(flash_oe_n)
);

// File: tb/flash_prog_seq_tb.sv
module flash_prog_seq_tb;
  localparam int AW = 24, DW = 16, WE_CYC = 3, OE_CYC = 2, MAX_POLLS = 8;

  logic clk = 0, rst_n = 0, start = 0, array_req = 0;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] data_in = '0;
  logic busy, done, flash_dq_oe, flash_ce_n, flash_we_n, flash_oe_n;
  logic [2:0] result;
  logic [AW-1:0] flash_addr;
  logic [DW-1:0] flash_dq_out;
  logic [7:0] flash_stat_in;

  int checks = 0, failures = 0;
  int m_busy = 0, rd_cnt = 0, exp_reads = 0, ops_done = 0;
  logic [7:0] m_err = 0;
  logic [AW+DW-1:0] wr_q[$];
  int res_q[$];
  time we_fall, oe_fall;

  always #5 clk = ~clk;

  flash_prog_seq #(.AW(AW), .DW(DW), .WE_CYC(WE_CYC), .OE_CYC(OE_CYC), .MAX_POLLS(MAX_POLLS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .array_req(array_req),
    .addr_in(addr_in), .data_in(data_in), .busy(busy), .done(done), .result(result),
    .flash_addr(flash_addr), .flash_dq_out(flash_dq_out), .flash_dq_oe(flash_dq_oe),
    .flash_stat_in(flash_stat_in), .flash_ce_n(flash_ce_n), .flash_we_n(flash_we_n),
    .flash_oe_n(flash_oe_n));

  assign flash_stat_in = (!flash_oe_n && rd_cnt >= m_busy) ? (8'h80 | m_err) : 8'h00;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge flash_we_n) if (rst_n) we_fall = $time;
  always @(posedge flash_we_n) if (rst_n) begin
    chk(($time - we_fall) == WE_CYC * 10, "R2 we width", $time - we_fall, WE_CYC * 10);
    chk(!flash_ce_n && flash_dq_oe, "R2 ce/oe during write", {flash_ce_n, flash_dq_oe}, 2'b01);
    if (wr_q.size() == 0) chk(0, "R8 unexpected write", {flash_addr, flash_dq_out}, 0);
    else begin
      logic [AW+DW-1:0] e;
      e = wr_q.pop_front();
      chk({flash_addr, flash_dq_out} == e, "R1/R5/R7 write", {flash_addr, flash_dq_out}, e);
    end
  end
  always @(negedge flash_oe_n) if (rst_n) oe_fall = $time;
  always @(posedge flash_oe_n) if (rst_n) begin
    rd_cnt++;
    chk(($time - oe_fall) == OE_CYC * 10, "R3 oe width", $time - oe_fall, OE_CYC * 10);
  end

  always @(negedge clk) if (rst_n && done) begin
    int e;
    e = (res_q.size() > 0) ? res_q.pop_front() : -1;
    chk(int'(result) == e, "R4/R6 result", result, e);
    chk(rd_cnt == exp_reads, "R3/R6 read count", rd_cnt, exp_reads);
    chk(wr_q.size() == 0, "R5 pending writes", wr_q.size(), 0);
    ops_done++;
  end

  task automatic run(input bit arr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input int nbusy, input logic [7:0] err, input int exp_res, input bit poke);
    int target;
    m_busy = nbusy; m_err = err; rd_cnt = 0;
    if (arr) begin
      wr_q.push_back({a, DW'(16'hFF)});
      exp_reads = 0;
    end else begin
      wr_q.push_back({a, DW'(16'h40)});
      wr_q.push_back({a, d});
      exp_reads = (nbusy >= MAX_POLLS) ? MAX_POLLS : nbusy + 1;
    end
    if (exp_res != 0) wr_q.push_back({a, DW'(16'h50)});
    res_q.push_back(exp_res);
    target = ops_done + 1;
    @(negedge clk);
    addr_in = a; data_in = d; array_req = arr; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy, "R8 busy after start", busy, 1);
    if (poke) begin
      repeat (4) @(negedge clk);
      addr_in = '1; array_req = 1; start = 1;
      @(negedge clk);
      start = 0; array_req = 0;
    end
    while (ops_done < target) @(negedge clk);
    @(negedge clk);
    chk(!busy && !done, "R8 idle after done", {busy, done}, 0);
  endtask

  initial begin
    #200000;
    chk(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && flash_ce_n && flash_we_n && flash_oe_n, "R9 reset state",
        {busy, done, flash_ce_n, flash_we_n, flash_oe_n}, 5'b00111);
    rst_n = 1;
    @(negedge clk);
    run(0, 24'h001234, 16'hBEEF, 0, 8'h00, 0, 0);
    run(0, 24'h00ABCD, 16'h1357, 3, 8'h00, 0, 0);
    run(0, 24'h100000, 16'h00AA, 1, 8'h08, 1, 0);
    run(0, 24'h100002, 16'h00AB, 0, 8'h1A, 1, 0);
    run(0, 24'h100004, 16'h00AC, 2, 8'h12, 2, 0);
    run(0, 24'h100006, 16'h00AD, 0, 8'h10, 3, 0);
    run(0, 24'h200000, 16'h5555, 100, 8'h00, 4, 0);
    run(1, 24'h000000, 16'h0000, 0, 8'h00, 0, 0);
    run(0, 24'h300000, 16'hCAFE, 2, 8'h00, 0, 1);
    repeat (5) @(negedge clk);
    chk(flash_we_n && flash_oe_n && !busy, "R8 ignored start left no activity",
        {flash_we_n, flash_oe_n, busy}, 3'b110);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule